// File: doc/BRIEF.md
# Serial Line Status Register

This block holds the 8-bit line status word of an asynchronous serial port. It is read by the host at register offset 5. It takes single-cycle event strobes from the transmit and receive paths and from the host: a holding-register write, a holding-to-shift transfer, a shift-complete, and a character-received strobe that carries the received data, parity bit and stop-bit sample. From these events it keeps the transmit-empty flags and the sticky receive flags. It also watches the receive line level and counts baud ticks to detect a break condition.

The host side uses three plain strobes: a status read, a receive-buffer read and a holding-register write. None of them has back-pressure. Every strobe counts in the cycle it is high, and the block never stalls. The status word is always visible on `status_o`. A status read clears the four error flags, with effect from the next cycle. Data-ready clears only on a receive-buffer read. A transmit-empty interrupt request is driven whenever the holding register is empty and the enable input is high.

The line configuration inputs set the timing of the break detector and the rules of the parity check. These inputs are the data length code, the stop-bit count and the parity enable, even-select and stick settings.

Top module: `ser_line_status`

## Requirements
- R1: After reset `status_o` is 8'h60. Bit 7 always reads 0. Bit 6 is transmitter-empty, bit 5 holding-empty, bit 4 break, bit 3 framing, bit 2 parity, bit 1 overrun and bit 0 data-ready.
- R2: Transmitter-empty (bit 6) is 1 only when neither the holding register nor the shift register holds a character.
- R3: Holding-empty (bit 5) goes to 0 in the cycle after a holding write. It goes to 1 in the cycle after a transfer into the shift register, unless a write arrives in the same cycle as that transfer. The shift register empties on shift-complete.
- R4: `tx_irq_o` is high exactly when bit 5 is 1 and `thre_ie_i` is 1.
- R5: Data-ready (bit 0) is set in the cycle after `rx_done_i`. It is cleared only by `rd_rbr_i`, and a status read leaves it unchanged.
- R6: Overrun (bit 1) is set when `rx_done_i` arrives while data-ready is 1 and `rd_rbr_i` is low in that same cycle.
- R7: Parity error (bit 2) is set on `rx_done_i` when `par_en_i` is 1 and the parity check fails. The data is masked to 5+`wlen_i` bits. In normal mode the XOR of the masked data and `rx_par_i` must be 0 for even (`par_even_i`=1) and 1 for odd. In stick mode (`par_stick_i`=1), `rx_par_i` must equal the inverse of `par_even_i`.
- R8: Framing error (bit 3) is set on `rx_done_i` when `rx_stop_i` is 0.
- R9: Break (bit 4) is set once the receive line has been 0 for more than 2×W+3 baud ticks. W is 1 + (5+`wlen_i`) + `par_en_i` + (`stop2_i` ? 2 : 1). The bit is visible in the cycle after tick number 2×W+4.
- R10: A status read clears bits 1 to 4 from the next cycle on.
- R11: When a set event and a clearing read of the same flag fall in one cycle, the flag is 1 afterwards.
- R12: The break tick count restarts whenever the line is 1. A continuous space raises break only once, so break stays 0 after a status read until the line has gone to 1 and a new full-length space has occurred.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_thr_i | input | 1 | Host writes the transmit holding register |
| rd_rbr_i | input | 1 | Host reads the receive buffer |
| rd_lsr_i | input | 1 | Host reads this status register |
| tx_xfer_i | input | 1 | Holding register moved into the shift register |
| tx_shift_done_i | input | 1 | Shift register finished sending |
| rx_done_i | input | 1 | Received character placed in the receive buffer |
| rx_data_i | input | 8 | Received data bits, qualified by rx_done_i |
| rx_par_i | input | 1 | Received parity bit, qualified by rx_done_i |
| rx_stop_i | input | 1 | Stop-bit sample, qualified by rx_done_i |
| rx_line_i | input | 1 | Receive line level (0 = space) |
| baud_tick_i | input | 1 | One pulse per bit time |
| wlen_i | input | 2 | Data length code (0 to 3 means 5 to 8 bits) |
| stop2_i | input | 1 | Two stop bits when 1 |
| par_en_i | input | 1 | Parity bit present and checked |
| par_even_i | input | 1 | Even parity select |
| par_stick_i | input | 1 | Stick parity select |
| thre_ie_i | input | 1 | Holding-empty interrupt enable |
| status_o | output | 8 | Line status word |
| tx_irq_o | output | 1 | Holding-empty interrupt request |

## Verification
A wrong transmit occupancy state shows on bits 5 and 6 and on `tx_irq_o` one cycle after the strobe that caused it. A wrong sticky flag shows on bits 0 to 4 in the cycle after the receive event or the host read. An off-by-one error in the break counter shows as bit 4 rising one tick early or late. Because of that, the bench checks the status word on both sides of the threshold tick and after the count has been restarted by a mark. Same-cycle set and clear collisions are driven on purpose, because a wrong priority only shows up in those cycles.

// File: rtl/ser_lsr_pkg.sv
package ser_lsr_pkg;

  typedef struct packed {
    logic [1:0] wlen;
    logic       stop2;
    logic       par_en;
    logic       par_even;
    logic       par_stick;
  } line_cfg_t;

  localparam int unsigned STAT_W = 8;
  localparam int unsigned DATA_W = 8;

  // Status bit positions (the host decodes these)
  localparam int unsigned B_DR   = 0;
  localparam int unsigned B_OE   = 1;
  localparam int unsigned B_PE   = 2;
  localparam int unsigned B_FE   = 3;
  localparam int unsigned B_BI   = 4;
  localparam int unsigned B_THRE = 5;
  localparam int unsigned B_TEMT = 6;

  // Bits per character frame: start + data + optional parity + stop bits
  function automatic logic [4:0] frame_bits(line_cfg_t c);
    return 5'd6 + {3'd0, c.wlen} + {4'd0, c.par_en} + (c.stop2 ? 5'd2 : 5'd1);
  endfunction

  function automatic logic parity_bad(line_cfg_t c, logic [DATA_W-1:0] d, logic pbit);
    logic [DATA_W-1:0] mask;
    mask = 8'hFF >> (2'd3 - c.wlen);
    if (c.par_stick) return pbit ^ ~c.par_even;
    return (^(d & mask)) ^ pbit ^ ~c.par_even;
  endfunction

endpackage

// File: rtl/lsr_tx_track.sv
module lsr_tx_track (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_thr_i,
  input  logic xfer_i,
  input  logic shift_done_i,
  output logic thre_o,
  output logic temt_o
);
  logic hold_full_q, shift_full_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_full_q  <= 1'b0;
      shift_full_q <= 1'b0;
    end else begin
      if (wr_thr_i)    hold_full_q <= 1'b1;
      else if (xfer_i) hold_full_q <= 1'b0;
      if (xfer_i)            shift_full_q <= 1'b1;
      else if (shift_done_i) shift_full_q <= 1'b0;
    end
  end

  assign thre_o = ~hold_full_q;
  assign temt_o = ~hold_full_q & ~shift_full_q;

  p_temt_needs_thre_r2: assert property (@(posedge clk) disable iff (!rst_n)
    temt_o |-> thre_o);
  p_write_fills_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_thr_i |=> !thre_o);
  p_xfer_empties_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_i && !wr_thr_i) |=> (thre_o && !temt_o));
endmodule

// File: rtl/lsr_break_det.sv
module lsr_break_det
  import ser_lsr_pkg::*;
#(
  parameter int unsigned CNT_W = 6
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      line_i,
  input  logic      tick_i,
  input  line_cfg_t cfg_i,
  output logic      brk_evt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] thr;

  // Threshold 2*W + 3; the event fires on the tick that goes past it
  assign thr = CNT_W'({frame_bits(cfg_i), 1'b0}) + CNT_W'(3);

  always_ff @(posedge clk) begin
    if (!rst_n)                         cnt_q <= '0;
    else if (line_i)                    cnt_q <= '0;
    else if (tick_i && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign brk_evt_o = !line_i && tick_i && (cnt_q == thr);

  p_cnt_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!line_i && !tick_i) |=> $stable(cnt_q));
  p_mark_restart_r12: assert property (@(posedge clk) disable iff (!rst_n)
    line_i |=> (cnt_q == '0));
endmodule

// File: rtl/lsr_rx_flags.sv
module lsr_rx_flags
  import ser_lsr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              par_i,
  input  logic              stop_i,
  input  logic              brk_evt_i,
  input  logic              rd_rbr_i,
  input  logic              rd_lsr_i,
  input  line_cfg_t         cfg_i,
  output logic              dr_o,
  output logic              oe_o,
  output logic              pe_o,
  output logic              fe_o,
  output logic              bi_o
);
  logic dr_q, oe_q, pe_q, fe_q, bi_q;
  logic set_oe, set_pe, set_fe;

  assign set_oe = done_i && dr_q && !rd_rbr_i;
  assign set_pe = done_i && cfg_i.par_en && parity_bad(cfg_i, data_i, par_i);
  assign set_fe = done_i && !stop_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dr_q <= 1'b0;
      oe_q <= 1'b0;
      pe_q <= 1'b0;
      fe_q <= 1'b0;
      bi_q <= 1'b0;
    end else begin
      // set has priority over the clearing read
      if (done_i)        dr_q <= 1'b1;
      else if (rd_rbr_i) dr_q <= 1'b0;
      if (set_oe)          oe_q <= 1'b1;
      else if (rd_lsr_i) oe_q <= 1'b0;
      if (set_pe)          pe_q <= 1'b1;
      else if (rd_lsr_i) pe_q <= 1'b0;
      if (set_fe)          fe_q <= 1'b1;
      else if (rd_lsr_i) fe_q <= 1'b0;
      if (brk_evt_i)       bi_q <= 1'b1;
      else if (rd_lsr_i) bi_q <= 1'b0;
    end
  end

  assign dr_o = dr_q;
  assign oe_o = oe_q;
  assign pe_o = pe_q;
  assign fe_o = fe_q;
  assign bi_o = bi_q;

  p_dr_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_i |=> dr_q);
  p_dr_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dr_q && !rd_rbr_i) |=> dr_q);
  p_overrun_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && dr_q && !rd_rbr_i) |=> oe_q);
  p_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && !stop_i) |=> fe_q);
  p_err_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_lsr_i && !done_i && !brk_evt_i) |=> (!oe_q && !pe_q && !fe_q && !bi_q));
  p_brk_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    brk_evt_i |=> bi_q);
endmodule

// File: rtl/ser_line_status.sv
module ser_line_status
  import ser_lsr_pkg::*;
#(
  parameter int unsigned CNT_W = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_thr_i,
  input  logic       rd_rbr_i,
  input  logic       rd_lsr_i,
  input  logic       tx_xfer_i,
  input  logic       tx_shift_done_i,
  input  logic       rx_done_i,
  input  logic [7:0] rx_data_i,
  input  logic       rx_par_i,
  input  logic       rx_stop_i,
  input  logic       rx_line_i,
  input  logic       baud_tick_i,
  input  logic [1:0] wlen_i,
  input  logic       stop2_i,
  input  logic       par_en_i,
  input  logic       par_even_i,
  input  logic       par_stick_i,
  input  logic       thre_ie_i,
  output logic [7:0] status_o,
  output logic       tx_irq_o
);
  line_cfg_t cfg;
  logic thre, temt, brk_evt;
  logic dr, oe, pe, fe, bi;

  assign cfg = '{wlen: wlen_i, stop2: stop2_i, par_en: par_en_i,
                 par_even: par_even_i, par_stick: par_stick_i};

  lsr_tx_track u_tx (
    .clk(clk), .rst_n(rst_n), .wr_thr_i(wr_thr_i), .xfer_i(tx_xfer_i),
    .shift_done_i(tx_shift_done_i), .thre_o(thre), .temt_o(temt));

  lsr_break_det #(.CNT_W(CNT_W)) u_brk (
    .clk(clk), .rst_n(rst_n), .line_i(rx_line_i), .tick_i(baud_tick_i),
    .cfg_i(cfg), .brk_evt_o(brk_evt));

  lsr_rx_flags u_rx (
    .clk(clk), .rst_n(rst_n), .done_i(rx_done_i), .data_i(rx_data_i),
    .par_i(rx_par_i), .stop_i(rx_stop_i), .brk_evt_i(brk_evt),
    .rd_rbr_i(rd_rbr_i), .rd_lsr_i(rd_lsr_i), .cfg_i(cfg),
    .dr_o(dr), .oe_o(oe), .pe_o(pe), .fe_o(fe), .bi_o(bi));

  always_comb begin
    status_o         = '0;
    status_o[B_DR]   = dr;
    status_o[B_OE]   = oe;
    status_o[B_PE]   = pe;
    status_o[B_FE]   = fe;
    status_o[B_BI]   = bi;
    status_o[B_THRE] = thre;
    status_o[B_TEMT] = temt;
  end

  assign tx_irq_o = thre & thre_ie_i;

  p_irq_enabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq_o |-> (thre_ie_i && status_o[B_THRE]));
  p_top_bit_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_lsr_i) |-> !status_o[7]);
endmodule

// File: tb/ser_line_status_tb_top.sv
module ser_line_status_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_thr = 0, rd_rbr = 0, rd_lsr = 0, xfer = 0, sdone = 0, rx_done = 0;
  logic [7:0] rx_data = 0;
  logic rx_par = 0, rx_stop = 1, rx_line = 1, tick = 0;
  logic [1:0] wlen = 2'd3;
  logic stop2 = 0, par_en = 0, par_even = 0, par_stick = 0, thre_ie = 0;
  logic [7:0] status;
  logic irq;
  int checks = 0, failures = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  ser_line_status dut_i (
    .clk(clk), .rst_n(rst_n), .wr_thr_i(wr_thr), .rd_rbr_i(rd_rbr),
    .rd_lsr_i(rd_lsr), .tx_xfer_i(xfer), .tx_shift_done_i(sdone),
    .rx_done_i(rx_done), .rx_data_i(rx_data), .rx_par_i(rx_par),
    .rx_stop_i(rx_stop), .rx_line_i(rx_line), .baud_tick_i(tick),
    .wlen_i(wlen), .stop2_i(stop2), .par_en_i(par_en), .par_even_i(par_even),
    .par_stick_i(par_stick), .thre_ie_i(thre_ie), .status_o(status),
    .tx_irq_o(irq));

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one clock with the currently driven strobes, then drop all strobes
  task automatic step();
    @(negedge clk);
    wr_thr = 0; rd_rbr = 0; rd_lsr = 0; xfer = 0; sdone = 0; rx_done = 0; tick = 0;
  endtask

  task automatic rx_char(logic [7:0] d, logic p, logic s);
    rx_data = d; rx_par = p; rx_stop = s; rx_done = 1; step();
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      tick = 1; step(); step();
    end
  endtask

  task automatic clear_all();
    rd_lsr = 1; rd_rbr = 1; step();
  endtask

  task automatic t_reset();
    chk("R1 reset status", status, 8'h60);
    chk("R4 reset irq off", {7'd0, irq}, 8'd0);
  endtask

  task automatic t_tx_flow();
    wr_thr = 1; step();
    chk("R3 write clears THRE", status, 8'h00);
    xfer = 1; step();
    chk("R2 shift busy", status, 8'h20);
    sdone = 1; step();
    chk("R2 both empty", status, 8'h60);
    wr_thr = 1; step();
    wr_thr = 1; xfer = 1; step();
    chk("R3 write with transfer", status, 8'h00);
    xfer = 1; step();
    chk("R3 second transfer", status, 8'h20);
    sdone = 1; step();
    chk("R2 drained", status, 8'h60);
  endtask

  task automatic t_irq();
    thre_ie = 1; step();
    chk("R4 irq on enable", {7'd0, irq}, 8'd1);
    wr_thr = 1; step();
    chk("R4 irq drops on write", {7'd0, irq}, 8'd0);
    xfer = 1; step();
    chk("R4 irq after transfer", {7'd0, irq}, 8'd1);
    sdone = 1; thre_ie = 0; step();
    chk("R4 irq disabled", {7'd0, irq}, 8'd0);
  endtask

  task automatic t_rx_ready();
    rx_char(8'h41, 0, 1);
    chk("R5 data ready set", status, 8'h61);
    rd_lsr = 1; step();
    chk("R5 status read keeps DR", status, 8'h61);
    rd_rbr = 1; step();
    chk("R5 buffer read clears DR", status, 8'h60);
  endtask

  task automatic t_overrun();
    rx_char(8'h11, 0, 1);
    rx_char(8'h22, 0, 1);
    chk("R6 overrun set", status, 8'h63);
    rd_lsr = 1; step();
    chk("R10 read clears OE", status, 8'h61);
    rd_rbr = 1; rx_done = 1; step();
    chk("R6 read with new char no OE", status, 8'h61);
    clear_all();
  endtask

  function automatic logic exp_pe(logic [1:0] wl, logic ev, logic st, logic [7:0] d, logic p);
    int ones = 0;
    for (int i = 0; i < 5 + wl; i++) ones += d[i];
    if (st) return ev ? p : !p;
    return ev ? ((ones + p) % 2 == 1) : ((ones + p) % 2 == 0);
  endfunction

  task automatic par_case(string tag, logic [1:0] wl, logic ev, logic st,
                          logic [7:0] d, logic p);
    wlen = wl; par_even = ev; par_stick = st; par_en = 1;
    rx_char(d, p, 1);
    chk(tag, status, exp_pe(wl, ev, st, d, p) ? 8'h65 : 8'h61);
    clear_all();
  endtask

  task automatic t_parity();
    par_case("R7 even bad", 2'd3, 1, 0, 8'h03, 1);
    par_case("R7 even good", 2'd3, 1, 0, 8'h07, 1);
    par_case("R7 odd good", 2'd3, 0, 0, 8'h03, 1);
    par_case("R7 5-bit mask", 2'd0, 1, 0, 8'hE1, 1);
    par_case("R7 stick good", 2'd3, 1, 1, 8'h00, 0);
    par_case("R7 stick bad", 2'd3, 1, 1, 8'h00, 1);
    par_en = 0; wlen = 2'd3;
    rx_char(8'h03, 1, 1);
    chk("R7 parity disabled", status, 8'h61);
    clear_all();
    chk("R10 all cleared", status, 8'h60);
  endtask

  task automatic t_frame_collide();
    rx_char(8'h55, 0, 0);
    chk("R8 framing set", status, 8'h69);
    rd_lsr = 1; rd_rbr = 1; rx_data = 8'h66; rx_stop = 0; rx_done = 1; step();
    chk("R11 set beats clear", status, 8'h69);
    rx_stop = 1;
    clear_all();
    chk("R10 framing cleared", status, 8'h60);
  endtask

  task automatic t_break();
    // 8 data bits, no parity, 1 stop: W=10, BI after 24 ticks
    wlen = 2'd3; par_en = 0; stop2 = 0;
    rx_line = 0;
    ticks(23);
    chk("R9 no break at threshold", status, 8'h60);
    ticks(1);
    chk("R9 break after 2W+4 ticks", status, 8'h70);
    rd_lsr = 1; step();
    ticks(5);
    chk("R12 single break per space", status, 8'h60);
    rx_line = 1; step();
    rx_line = 0;
    ticks(20);
    rx_line = 1; step();
    rx_line = 0;
    ticks(20);
    chk("R12 mark restarts count", status, 8'h60);
    rx_line = 1; step();
    // 5 data bits, 2 stop: W=8, BI after 20 ticks
    wlen = 2'd0; stop2 = 1;
    rx_line = 0;
    ticks(19);
    chk("R9 short frame before", status, 8'h60);
    ticks(1);
    chk("R9 short frame break", status, 8'h70);
    rx_line = 1; rd_lsr = 1; step();
    chk("R10 break cleared", status, 8'h60);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_tx_flow();
    t_irq();
    t_rx_ready();
    t_overrun();
    t_parity();
    t_frame_collide();
    t_break();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule